// File: doc/BRIEF.md
# Oversampled Serial Receiver with Address Filter

This block receives asynchronous serial frames from a single RX line. A 16x sample-enable pulse drives it. It waits for a falling edge and confirms the start bit at the middle of that bit. It then reads the data bits at the centre of each bit period, followed by an optional parity bit and one or two stop bits. Each completed word goes into a four-entry receive queue together with its own parity and framing flags. The host reads the head entry and pops it with a read strobe.

A 9-bit mode is available, and in it an address filter can be armed. While the filter is armed, every frame whose ninth bit is zero is dropped, and only address frames are kept. A line that stays low for a whole frame, stop bits included, produces a break pulse and stores nothing. Overrun is sticky. Parity errors, framing errors and overrun all feed one combined error output, and the host clears it with a pulse. A ready-to-send output falls when the queue has no free entry.

Top module: `uart_addr_rx`

## Requirements
- R1: In idle, a falling edge starts a frame only if the line is still low on the 8th sample tick, counting the tick that saw it low as the first. A shorter low pulse stores nothing.
- R2: With `nine_bit`=0 the block reads 8 data bits, least significant bit first, each one at the 16th tick after the previous sample point. The stored word has bit 8 equal to 0.
- R3: With `nine_bit`=1 the block reads 9 data bits, least significant first, and stores all 9. No parity bit is expected, and `rperr` is 0 whatever `par_mode` holds.
- R4: `par_mode` is decoded as 0 = no parity, 1 = even, 2 = odd and 3 = no parity. It applies only in 8-bit mode, where a parity bit follows the data. The entry's `rperr` is 1 when the parity sum of the data and the parity bit does not match the selected sense.
- R5: `two_stop` chooses one or two stop bits. If the first stop bit is low, the entry's `rferr` is set. The level of the second stop bit is not checked.
- R6: The queue holds 4 entries in arrival order. `rvalid` is high while it holds at least one entry, `rdata`, `rperr` and `rferr` show the oldest entry, and `rd` pops it.
- R7: A frame that completes while the queue is full is discarded, and the sticky `overrun` output is set. The queued entries are kept unchanged.
- R8: With `addr_en`=1 in 9-bit mode, frames whose ninth bit is 0 are dropped, and frames whose ninth bit is 1 are stored.
- R9: A frame in which every sampled bit is low, from the data bits through the last stop bit, produces a one-cycle `brk` pulse and stores no entry.
- R10: `rts` is low exactly while all 4 queue entries are occupied.
- R11: `err` is set when a stored frame carries a parity or framing error, or when an overrun occurs. `err` and `overrun` both stay set until an `err_clr` pulse.
- R12: Reception advances only on cycles where `tick16` is high, so a frame still decodes correctly when the ticks are spread several clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Sample enable at 16 times the bit rate |
| rxd | input | 1 | Serial line, idles high |
| nine_bit | input | 1 | 1 selects 9 data bits |
| par_mode | input | 2 | 0 none, 1 even, 2 odd, 3 none |
| two_stop | input | 1 | 1 expects two stop bits |
| addr_en | input | 1 | Arms the address filter in 9-bit mode |
| rd | input | 1 | Pops the head entry |
| err_clr | input | 1 | Clears err and overrun |
| rvalid | output | 1 | Queue not empty |
| rdata | output | 9 | Head entry data |
| rperr | output | 1 | Head entry parity error |
| rferr | output | 1 | Head entry framing error |
| overrun | output | 1 | Sticky overrun flag |
| err | output | 1 | Sticky combined error |
| brk | output | 1 | One-cycle break indication |
| rts | output | 1 | High while the queue has a free entry |

## Verification
A sample counter that is off by one moves every sample point away from the bit centre. Because the bench holds each bit for exactly 16 ticks, this shows up as a wrong value in `rdata` on the first data value that has a bit transition at the affected position, within a single frame. A bit index or a frame state that goes wrong shifts the word or reports a spurious framing error, and the host sees this at the next pop. Corruption of a queue pointer shows up as wrong ordering, as `rts` or `rvalid` at the wrong occupancy, or as a missing overrun within four or five frames.

// File: rtl/uart_addr_rx.sv
module uart_addr_rx #(
  parameter int DEPTH = 4,
  parameter int OSR   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rxd,
  input  logic       nine_bit,
  input  logic [1:0] par_mode,
  input  logic       two_stop,
  input  logic       addr_en,
  input  logic       rd,
  input  logic       err_clr,
  output logic       rvalid,
  output logic [8:0] rdata,
  output logic       rperr,
  output logic       rferr,
  output logic       overrun,
  output logic       err,
  output logic       brk,
  output logic       rts
);
  localparam int AW  = $clog2(DEPTH);
  localparam int CW  = $clog2(OSR);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 2);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP1, S_STOP2} st_t;

  st_t st;
  logic [1:0]    sync;
  logic [CW-1:0] sc;
  logic [3:0]    bi;
  logic [8:0]    sh;
  logic          pb, fe, zero, hi_seen;

  wire rx      = sync[1];
  wire at_mid  = tick16 && (sc == LAST);
  wire use_par = !nine_bit && (par_mode == 2'd1 || par_mode == 2'd2);
  wire [3:0] nb_last = nine_bit ? 4'd8 : 4'd7;

  wire [8:0] word   = nine_bit ? sh : {1'b0, sh[8:1]};
  wire       psum   = ^word[7:0] ^ pb;
  wire       perr_n = use_par && ((par_mode == 2'd1) ? psum : !psum);
  wire       done   = at_mid && ((st == S_STOP1 && !two_stop) || st == S_STOP2);
  wire       brk_n  = zero && !rx;
  wire       fe_n   = (st == S_STOP1) ? !rx : fe;
  wire       keep   = !(addr_en && nine_bit && !word[8]);

  logic [10:0] mem [DEPTH];
  logic [AW:0] wp, rp;
  wire  [AW:0] fcnt = wp - rp;
  wire         full = (fcnt == (AW+1)'(DEPTH));
  wire         take = done && !brk_n && keep;
  wire         push = take && !full;
  wire         ovf  = take && full;
  wire         pop  = rd && rvalid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync <= 2'b11; st <= S_IDLE; sc <= '0; bi <= '0; sh <= '0;
      pb <= 1'b0; fe <= 1'b0; zero <= 1'b0; hi_seen <= 1'b0; brk <= 1'b0;
    end else begin
      sync <= {sync[0], rxd};
      brk  <= 1'b0;
      if (st == S_IDLE && rx) hi_seen <= 1'b1;
      if (tick16) begin
        case (st)
          S_IDLE: if (!rx && hi_seen) begin
            st <= S_START; sc <= '0; hi_seen <= 1'b0;
          end
          S_START: if (sc == MID) begin
            sc <= '0;
            if (!rx) begin
              st <= S_DATA; bi <= '0; sh <= '0; zero <= 1'b1; fe <= 1'b0;
            end else st <= S_IDLE;
          end else sc <= sc + 1'b1;
          S_DATA: if (sc == LAST) begin
            sc <= '0; sh <= {rx, sh[8:1]}; zero <= zero && !rx; bi <= bi + 1'b1;
            if (bi == nb_last) st <= use_par ? S_PAR : S_STOP1;
          end else sc <= sc + 1'b1;
          S_PAR: if (sc == LAST) begin
            sc <= '0; pb <= rx; zero <= zero && !rx; st <= S_STOP1;
          end else sc <= sc + 1'b1;
          S_STOP1: if (sc == LAST) begin
            sc <= '0; fe <= !rx; zero <= zero && !rx;
            if (two_stop) st <= S_STOP2;
            else begin st <= S_IDLE; brk <= brk_n; end
          end else sc <= sc + 1'b1;
          S_STOP2: if (sc == LAST) begin
            sc <= '0; st <= S_IDLE; brk <= brk_n;
          end else sc <= sc + 1'b1;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) if (push) mem[wp[AW-1:0]] <= {fe_n, perr_n, word};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; overrun <= 1'b0; err <= 1'b0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      if (ovf) overrun <= 1'b1;
      else if (err_clr) overrun <= 1'b0;
      if (ovf || (push && (fe_n || perr_n))) err <= 1'b1;
      else if (err_clr) err <= 1'b0;
    end
  end

  assign rvalid = (fcnt != '0);
  assign rts    = !full;
  assign {rferr, rperr, rdata} = mem[rp[AW-1:0]];
endmodule

module uart_addr_rx_chk #(
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd,
  input logic          err_clr,
  input logic          rvalid,
  input logic          rts,
  input logic          overrun,
  input logic          err,
  input logic          brk,
  input logic [CW-1:0] cnt
);
  AST_RTS_MEANS_DATA: assert property (@(posedge clk) disable iff (!rst_n) !rts |-> rvalid); // R10
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(DEPTH)); // R6
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (cnt == CW'(DEPTH) && !rd) |=> cnt == CW'(DEPTH)); // R7
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (overrun && !err_clr) |=> overrun); // R7
  AST_OVR_ERR: assert property (@(posedge clk) disable iff (!rst_n) overrun |-> err); // R11
  AST_BRK_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n) (brk && !$past(rd)) |-> cnt == $past(cnt)); // R9
endmodule

bind uart_addr_rx uart_addr_rx_chk #(.DEPTH(DEPTH), .CW(AW+1)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd(rd), .err_clr(err_clr), .rvalid(rvalid), .rts(rts),
  .overrun(overrun), .err(err), .brk(brk), .cnt(fcnt)
);

// File: tb/uart_addr_rx_test.sv
module uart_addr_rx_test;
  logic clk = 0, rst_n = 0, tick16 = 0, rxd = 1;
  logic nine_bit = 0, two_stop = 0, addr_en = 0, rd = 0, err_clr = 0;
  logic [1:0] par_mode = 0;
  logic rvalid, rperr, rferr, overrun, err, brk, rts;
  logic [8:0] rdata;
  int checks = 0, errors = 0, nbrk = 0, tdiv = 1, tc = 0;

  uart_addr_rx uut (.*);

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (tc >= tdiv - 1) begin tc <= 0; tick16 <= 1'b1; end
    else begin tc <= tc + 1; tick16 <= 1'b0; end
    if (brk) nbrk <= nbrk + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bitt(input logic v);
    rxd <= v;
    repeat (16 * tdiv) @(posedge clk);
  endtask

  task automatic send(input logic [8:0] d, input int nb, input bit usepar, input logic pbit,
                      input logic s1, input logic s2);
    bitt(1'b0);
    for (int i = 0; i < nb; i++) bitt(d[i]);
    if (usepar) bitt(pbit);
    bitt(s1);
    if (two_stop) bitt(s2);
    rxd <= 1'b1;
    repeat (32 * tdiv) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pop();
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic clr();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    rst_n = 1;
    repeat (40) @(posedge clk);
    @(negedge clk);
    chk("R6 reset rvalid", rvalid, 0);
    chk("R10 reset rts", rts, 1);
    chk("R11 reset err", err, 0);
    chk("R7 reset overrun", overrun, 0);

    for (int v = 0; v < 256; v++) begin
      send(9'(v), 8, 0, 0, 1, 1);
      chk("R2 data", {rvalid, rferr, rperr, rdata}, {1'b1, 2'b00, 9'(v)});
      pop();
    end

    for (int m = 1; m <= 3; m++) begin
      par_mode = 2'(m);
      for (int v = 0; v < 256; v += 4) begin
        logic good, pb;
        good = ((v >> 2) % 2) == 0;
        pb = (m == 2) ? ~(^8'(v)) : (^8'(v));
        if (!good) pb = ~pb;
        if (m == 3) begin
          send(9'(v), 8, 0, 0, 1, 1);
          chk("R4 no parity mode 3", {rperr, rdata}, {1'b0, 9'(v)});
        end else begin
          send(9'(v), 8, 1, pb, 1, 1);
          chk("R4 parity flag", {rperr, rdata}, {!good, 9'(v)});
        end
        pop();
      end
    end

    nine_bit = 1; par_mode = 1;
    for (int v = 0; v < 512; v += 5) begin
      send(9'(v), 9, 0, 0, 1, 1);
      chk("R3 nine bit data", {rvalid, rperr, rdata}, {1'b1, 1'b0, 9'(v)});
      pop();
    end
    par_mode = 0;

    addr_en = 1;
    send(9'h012, 9, 0, 0, 1, 1);
    chk("R8 data frame dropped", rvalid, 0);
    send(9'h1A5, 9, 0, 0, 1, 1);
    chk("R8 address stored", {rvalid, rdata}, {1'b1, 9'h1A5});
    send(9'h034, 9, 0, 0, 1, 1);
    pop();
    chk("R8 second data frame dropped", rvalid, 0);
    addr_en = 0; nine_bit = 0;

    send(9'h055, 8, 0, 0, 0, 1);
    chk("R5 framing flag", {rferr, rdata}, {1'b1, 9'h055});
    chk("R11 err on framing", err, 1);
    pop();
    clr();
    chk("R11 err cleared", err, 0);

    two_stop = 1;
    send(9'h03C, 8, 0, 0, 1, 1);
    chk("R5 two stop ok", {rferr, rdata}, {1'b0, 9'h03C});
    pop();
    send(9'h0C5, 8, 0, 0, 1, 0);
    chk("R5 second stop unchecked", {rferr, rdata}, {1'b0, 9'h0C5});
    pop();
    send(9'h0A0, 8, 0, 0, 0, 1);
    chk("R5 first stop low in two stop", {rferr, rdata}, {1'b1, 9'h0A0});
    pop();
    clr();
    two_stop = 0;

    for (int k = 0; k < 5; k++) begin
      send(9'(8'hA0 + k), 8, 0, 0, 1, 1);
      if (k == 3) begin
        chk("R10 rts low when full", rts, 0);
        chk("R7 no overrun yet", overrun, 0);
      end
    end
    chk("R7 overrun set", overrun, 1);
    chk("R11 err on overrun", err, 1);
    for (int k = 0; k < 4; k++) begin
      chk("R6 fifo order", {rvalid, rdata}, {1'b1, 9'(8'hA0 + k)});
      pop();
      chk("R10 rts high after pop", rts, 1);
    end
    chk("R6 empty after drain", rvalid, 0);
    chk("R7 overrun sticky", overrun, 1);
    clr();
    chk("R11 overrun cleared", {overrun, err}, 2'b00);

    begin
      int b0;
      b0 = nbrk;
      send(9'h000, 8, 0, 0, 0, 0);
      chk("R9 break pulse", nbrk - b0, 1);
      chk("R9 break not stored", rvalid, 0);
      chk("R9 break no error", err, 0);
    end

    @(negedge clk);
    rxd <= 1'b0;
    repeat (5 * tdiv) @(posedge clk);
    rxd <= 1'b1;
    repeat (400) @(posedge clk);
    @(negedge clk);
    chk("R1 short low ignored", rvalid, 0);
    send(9'h081, 8, 0, 0, 1, 1);
    chk("R1 frame after noise", {rvalid, rdata}, {1'b1, 9'h081});
    pop();

    tdiv = 3;
    repeat (10) @(posedge clk);
    send(9'h0C3, 8, 0, 0, 1, 1);
    chk("R12 slow tick frame", {rvalid, rferr, rdata}, {1'b1, 1'b0, 9'h0C3});
    pop();
    send(9'h03A, 8, 0, 0, 1, 1);
    chk("R12 slow tick second frame", {rvalid, rdata}, {1'b1, 9'h03A});
    pop();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule